// File: doc/BRIEF.md
# Half to double widening converter

This unit widens an IEEE 754 binary16 bit pattern into the binary64 bit pattern of exactly the same value. Because every binary16 value can be represented in binary64, no rounding takes place. Each input is decoded into sign, 5-bit exponent and 10-bit fraction and sorted into one class: zero, subnormal, normal, infinity or NaN. Each class then produces its own output field values.

A subnormal input has no implicit one. A priority encoder finds the leading one of its fraction in a single pass, with no iterative loop. The fraction is shifted so that this leading one becomes the implicit bit and is dropped. The exponent is lowered by the same shift count, so the result is always a binary64 normal.

NaN payloads and signs pass through unchanged and are never quieted. The result is registered: a valid-qualified input produces a valid-qualified output one clock later.

Top module: `half_to_double_widen`

## Requirements
- R1: The output sign bit 63 always equals the input sign bit 15, for every class.
- R2: An input with exponent field bits 14:10 equal to 0 and fraction bits 9:0 equal to 0 gives a zero: output bits 62:0 are all 0.
- R3: For a normal input (exponent field 1 to 30), the output exponent bits 62:52 equal the input exponent plus 1008. Output bits 51:42 equal the input fraction, and bits 41:0 are 0.
- R4: A subnormal input (exponent field 0, fraction nonzero) gives a binary64 normal.
  - Let z be the count of leading zeros of the 10-bit fraction.
  - The output exponent is 1008 minus z.
  - Output bits 51:42 hold the fraction shifted left by z+1 and truncated to 10 bits.
  - Bits 41:0 are 0.
- R5: An input with exponent field 31 and fraction 0 gives an infinity: output exponent 0x7FF and output bits 51:0 all 0.
- R6: An input with exponent field 31 and a nonzero fraction gives a NaN.
  - The output exponent is 0x7FF.
  - Output bits 51:42 equal the input fraction unchanged, so the quiet bit is not forced.
  - Bits 41:0 are 0.
- R7: out_valid is high in the cycle after a clock edge that sampled in_valid high, and low otherwise. The result for that input is on out_dbl in the same cycle.
- R8: A synchronous active-high reset drives out_valid low on the next edge, whatever in_valid is.
- R9: When in_valid is low at an edge, out_dbl keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_half |
| in_half | input | 16 | binary16 bit pattern |
| out_valid | output | 1 | Qualifies out_dbl, one clock after in_valid |
| out_dbl | output | 64 | binary64 bit pattern of the same value |

## Verification
The subnormal path is the hard part. There are ten distinct leading-zero counts, and each one needs its own shift and exponent, so a single wrong encoder entry would hide among thousands of normal inputs. The stimulus therefore sweeps every one of the 65536 input patterns back to back. This reaches every leading-one position with both signs and every NaN payload, including the signalling payloads that must not be quieted. The bench reference computes each finite value arithmetically as a real number and converts it to bits, which gives an independent check of the renormalisation.

// File: rtl/half_to_double_widen.sv
module half_to_double_widen (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [15:0] in_half,
  output logic        out_valid,
  output logic [63:0] out_dbl
);
  localparam int HFRAC  = 10;
  localparam int HEXP   = 5;
  localparam int DFRAC  = 52;
  localparam int DEXP   = 11;
  localparam int HBIAS  = 15;
  localparam int DBIAS  = 1023;
  localparam int PAD    = DFRAC - HFRAC;
  localparam int REBIAS = DBIAS - HBIAS;
  localparam logic [HEXP-1:0] HEXP_TOP = '1;
  localparam logic [DEXP-1:0] DEXP_TOP = '1;

  logic            sgn;
  logic [HEXP-1:0] hexp;
  logic [HFRAC-1:0] hfrac;
  logic [3:0]      lz;
  logic [HFRAC-1:0] sub_frac;
  logic [DEXP-1:0] res_exp;
  logic [HFRAC-1:0] res_frac;

  assign sgn   = in_half[15];
  assign hexp  = in_half[14:10];
  assign hfrac = in_half[9:0];

  always_comb begin
    logic found;
    found = 1'b0;
    lz = 4'd0;
    for (int i = HFRAC - 1; i >= 0; i--) begin
      if (!found && hfrac[i]) begin
        lz = 4'(HFRAC - 1 - i);
        found = 1'b1;
      end
    end
  end

  assign sub_frac = hfrac << (lz + 4'd1);

  always_comb begin
    if (hexp == '0) begin
      if (hfrac == '0) begin
        res_exp  = '0;
        res_frac = '0;
      end else begin
        res_exp  = DEXP'(REBIAS) - DEXP'(lz);
        res_frac = sub_frac;
      end
    end else if (hexp == HEXP_TOP) begin
      res_exp  = DEXP_TOP;
      res_frac = hfrac;
    end else begin
      res_exp  = DEXP'(hexp) + DEXP'(REBIAS);
      res_frac = hfrac;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_dbl   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_dbl <= {sgn, res_exp, res_frac, {PAD{1'b0}}};
    end
  end

  a_r1_sign_kept: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_dbl[63] == $past(in_half[15]));

  a_r2_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half[14:0] == 15'd0) |=> out_dbl[62:0] == 63'd0);

  a_r3_normal_frac: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half[14:10] != 5'd0 && in_half[14:10] != 5'd31)
      |=> (out_dbl[51:42] == $past(in_half[9:0]) && out_dbl[41:0] == 42'd0));

  a_r4_sub_range: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half[14:10] == 5'd0 && in_half[9:0] != 10'd0)
      |=> (out_dbl[62:52] >= 11'd999 && out_dbl[62:52] <= 11'd1008 && out_dbl[41:0] == 42'd0));

  a_r5_inf: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half[14:0] == 15'h7c00) |=> (out_dbl[62:52] == 11'h7ff && out_dbl[51:0] == 52'd0));

  a_r6_nan_payload: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half[14:10] == 5'd31 && in_half[9:0] != 10'd0)
      |=> (out_dbl[62:52] == 11'h7ff && out_dbl[51:42] == $past(in_half[9:0])));

  a_r7_latency_hi: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r7_latency_lo: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_dbl));
endmodule

// File: tb/tb_half_to_double_widen.sv
module tb_half_to_double_widen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = 16'd0;
  logic        out_valid;
  logic [63:0] out_dbl;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  half_to_double_widen dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
    .out_valid(out_valid), .out_dbl(out_dbl)
  );

  always #5 clk = ~clk;

  function automatic logic [63:0] ref_conv(input logic [15:0] h);
    logic [4:0] e;
    logic [9:0] f;
    real v;
    logic [63:0] b;
    e = h[14:10];
    f = h[9:0];
    if (e == 5'd31) begin
      b = {h[15], 11'h7ff, f, 42'd0};
    end else if (e == 5'd0 && f == 10'd0) begin
      b = {h[15], 63'd0};
    end else begin
      if (e == 5'd0) v = real'(f) * (2.0 ** (-24.0));
      else v = real'(1024 + int'(f)) * (2.0 ** (real'(int'(e) - 25)));
      b = $realtobits(v);
      b[63] = h[15];
    end
    return b;
  endfunction

  function automatic string req_of(input logic [15:0] h);
    if (h[14:10] == 5'd31) return (h[9:0] == 10'd0) ? "R5" : "R6";
    if (h[14:10] == 5'd0) return (h[9:0] == 10'd0) ? "R2" : "R4";
    return "R3";
  endfunction

  task automatic check64(input string rq, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic check1(input string rq, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check1("R8", out_valid, 1'b0);
    check64("R8", out_dbl, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check1("R7", out_valid, 1'b0);
    // exhaustive sweep, back to back; R1 sign covered by every compare
    in_half = 16'd0;
    in_valid = 1'b1;
    for (int p = 1; p <= 65536; p++) begin
      logic [15:0] prev;
      prev = in_half;
      @(negedge clk);
      if (p < 65536) in_half = 16'(p);
      check1("R7", out_valid, 1'b1);
      check64(req_of(prev), out_dbl, ref_conv(prev));
      if (prev[14:10] != 5'd31)
        check1("R1", out_dbl[63], prev[15]);
    end
    // idle: output holds last value (R9), valid drops (R7)
    in_valid = 1'b0;
    in_half = 16'h3c00;
    held = ref_conv(16'hffff);
    @(negedge clk);
    check1("R7", out_valid, 1'b0);
    check64("R9", out_dbl, held);
    @(negedge clk);
    check64("R9", out_dbl, held);
    // single pulse after idle
    in_valid = 1'b1;
    in_half = 16'h0001;
    @(negedge clk);
    in_valid = 1'b0;
    check1("R7", out_valid, 1'b1);
    check64("R4", out_dbl, 64'h3e70000000000000);
    // reset with in_valid high
    in_valid = 1'b1;
    in_half = 16'h7e00;
    rst = 1'b1;
    @(negedge clk);
    check1("R8", out_valid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check1("R7", out_valid, 1'b1);
    check64("R6", out_dbl, 64'h7ff8000000000000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule